// File: doc/BRIEF.md
# Radio Transceiver State Command Controller

This block sequences a packet radio among its operating states under host control. The host writes one 8-bit control register. The low five bits carry a command code, and the controller decodes them into a move between power-on, off, PLL-ready, receive and transmit. Two extended modes are also reachable: receive with automatic acknowledge and transmit with automatic retry. The top three bits of the same register read back a transaction status, and the host cannot write them.

The radio front end, the synthesiser and the extended procedures themselves are outside the block. Each of them is represented by a plain completion strobe carrying a result code. A symbol-period tick paces the start of a frame. An external trigger releases a slotted acknowledge. The register port is a plain write strobe with data and a combinational read value. It has no back-pressure: every write is consumed in the cycle it is presented.

Top module: `radio_state_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `state_o` is 0 (power-on), and `tx_go`, `trac_irq` and `ack_go` are low.
- R2: A write stores bits 4:0 as the command field, and that field reads back the last value written, including reserved codes. Bits 7:5 of a write are ignored; they always read the status.
- R3: State codes are 0 power-on, 1 off, 2 PLL-ready, 3 receive, 4 transmit-wait, 5 transmit-busy, 6 auto-ACK receive, 7 auto-retry transmit and 8 sleep. The idle states are 1, 2, 3, 6 and 7. From an idle state, the following commands take effect at the clock edge of the write: 0x08 goes to 1, 0x09 goes to 2 and 0x06 goes to 3. The command 0x03 goes to 1 from any state except sleep.
- R4: Command 0x00, and every code outside 0x02, 0x03, 0x04, 0x06, 0x08, 0x09, 0x16 and 0x19, leaves the state unchanged.
- R5: Command 0x02 is accepted only in state 2 and moves to state 4. At the first `sym_tick` sampled in state 4, the controller enters state 5 and pulses `tx_go` for one cycle. `proc_done` in state 5 returns to state 2. In states 4 and 5, only 0x03 and 0x04 are obeyed.
- R6: Command 0x04 moves to state 2 from any state except power-on and sleep, and in those two states it is ignored. Power-on is left only by 0x08 or 0x03.
- R7: In state 1, a high `sleep_req` with no accepted command moves to state 8. In state 8 every command is ignored, and a low `sleep_req` returns to state 1.
- R8: Commands 0x16 (to state 6) and 0x19 (to state 7) are accepted from an idle state only while `ext_mode_en` is high; otherwise they are ignored.
- R9: Accepting 0x16 or 0x19 sets the status to 7 (INVALID) in the same edge.
- R10: `proc_done` in state 6 or 7 loads the status with `proc_result` and pulses `trac_irq` for one cycle. In state 6 only 0 and 2 are kept; in state 7 only 0, 1, 3 and 5 are kept. Any other result is stored as 7.
- R11: Status 2 (wait-for-ACK) is kept only if `slotted_en` is high at completion. While in state 6 with status 2, `ack_trigger` produces a one-cycle `ack_go` on the next edge.
- R12: The status holds across all non-extended commands until the next extended procedure starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value {status, command} |
| ext_mode_en | input | 1 | Extended operating mode enable |
| slotted_en | input | 1 | Slotted acknowledge operation enable |
| sym_tick | input | 1 | One-cycle pulse per symbol period |
| sleep_req | input | 1 | Sleep request level |
| proc_done | input | 1 | Completion strobe of frame or extended procedure |
| proc_result | input | 3 | Result code presented with proc_done |
| ack_trigger | input | 1 | External slotted-ACK release pulse |
| state_o | output | 4 | Current state code |
| tx_go | output | 1 | Frame transmission start pulse |
| trac_irq | output | 1 | Extended procedure completion pulse |
| ack_go | output | 1 | Slotted ACK transmission pulse |

## Verification
The bench writes 0x04 in power-on and in sleep. A design without the exclusion would jump to PLL-ready. It also writes a command with the status bits set, which a wrong design would let overwrite the status. A transmit start is followed by a stray receive command and then a late symbol tick: a controller that skipped the wait would pulse `tx_go` at once, and one that did not lock out commands would leave for receive. Completions carry results illegal for the current mode or without slotted operation. A design that forwarded the raw result would report 2 where 7 is due. The status is re-read after plain commands, which catches a design that clears it early.

// File: rtl/radio_ctrl_pkg.sv
package radio_ctrl_pkg;
  localparam int CMD_W  = 5;
  localparam int STAT_W = 3;
  localparam int REG_W  = CMD_W + STAT_W;

  typedef enum logic [3:0] {
    ST_POWERON = 4'd0, ST_OFF    = 4'd1, ST_PLL     = 4'd2,
    ST_RX      = 4'd3, ST_TXWAIT = 4'd4, ST_TXBUSY  = 4'd5,
    ST_RXAUTO  = 4'd6, ST_TXRTRY = 4'd7, ST_SLEEP   = 4'd8
  } rstate_t;

  typedef enum logic [3:0] {
    OP_NONE, OP_TXGO, OP_FOFF, OP_FPLL, OP_RX, OP_OFF, OP_PLL,
    OP_RXAUTO, OP_TXRTRY
  } op_t;

  localparam logic [CMD_W-1:0] CODE_TXGO   = 5'h02;
  localparam logic [CMD_W-1:0] CODE_FOFF   = 5'h03;
  localparam logic [CMD_W-1:0] CODE_FPLL   = 5'h04;
  localparam logic [CMD_W-1:0] CODE_RX     = 5'h06;
  localparam logic [CMD_W-1:0] CODE_OFF    = 5'h08;
  localparam logic [CMD_W-1:0] CODE_PLL    = 5'h09;
  localparam logic [CMD_W-1:0] CODE_RXAUTO = 5'h16;
  localparam logic [CMD_W-1:0] CODE_TXRTRY = 5'h19;

  localparam logic [STAT_W-1:0] TS_OK      = 3'd0;
  localparam logic [STAT_W-1:0] TS_PEND    = 3'd1;
  localparam logic [STAT_W-1:0] TS_WAITACK = 3'd2;
  localparam logic [STAT_W-1:0] TS_CAF     = 3'd3;
  localparam logic [STAT_W-1:0] TS_NOACK   = 3'd5;
  localparam logic [STAT_W-1:0] TS_INVALID = 3'd7;
endpackage

// File: rtl/radio_cmd_decode.sv
module radio_cmd_decode
  import radio_ctrl_pkg::*;
(
  input  logic [CMD_W-1:0] code,
  output op_t              op
);
  always_comb begin
    case (code)
      CODE_TXGO:   op = OP_TXGO;
      CODE_FOFF:   op = OP_FOFF;
      CODE_FPLL:   op = OP_FPLL;
      CODE_RX:     op = OP_RX;
      CODE_OFF:    op = OP_OFF;
      CODE_PLL:    op = OP_PLL;
      CODE_RXAUTO: op = OP_RXAUTO;
      CODE_TXRTRY: op = OP_TXRTRY;
      default:     op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/radio_state_seq.sv
module radio_state_seq
  import radio_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  op_t     op,
  input  logic    ext_en,
  input  logic    sym_tick,
  input  logic    done,
  input  logic    sleep_req,
  output rstate_t state,
  output logic    tx_go,
  output logic    ext_start
);
  rstate_t nxt;
  logic    took, go;
  logic    idle, locked;

  assign idle   = (state == ST_OFF) || (state == ST_PLL) || (state == ST_RX) ||
                  (state == ST_RXAUTO) || (state == ST_TXRTRY);
  assign locked = (state == ST_POWERON) || (state == ST_SLEEP);

  always_comb begin
    nxt       = state;
    ext_start = 1'b0;
    go        = 1'b0;
    if (wr) begin
      case (op)
        OP_FOFF:   if (state != ST_SLEEP) nxt = ST_OFF;
        OP_FPLL:   if (!locked) nxt = ST_PLL;
        OP_OFF:    if (idle || state == ST_POWERON) nxt = ST_OFF;
        OP_PLL:    if (idle) nxt = ST_PLL;
        OP_RX:     if (idle) nxt = ST_RX;
        OP_TXGO:   if (state == ST_PLL) nxt = ST_TXWAIT;
        OP_RXAUTO: if (idle && ext_en) begin nxt = ST_RXAUTO; ext_start = 1'b1; end
        OP_TXRTRY: if (idle && ext_en) begin nxt = ST_TXRTRY; ext_start = 1'b1; end
        default:   nxt = state;
      endcase
    end
    took = (nxt != state) || ext_start;
    if (!took) begin
      case (state)
        ST_TXWAIT: if (sym_tick) begin nxt = ST_TXBUSY; go = 1'b1; end
        ST_TXBUSY: if (done) nxt = ST_PLL;
        ST_OFF:    if (sleep_req) nxt = ST_SLEEP;
        ST_SLEEP:  if (!sleep_req) nxt = ST_OFF;
        default:   nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_POWERON;
      tx_go <= 1'b0;
    end else begin
      state <= nxt;
      tx_go <= go;
    end
  end
endmodule

// File: rtl/radio_trac_unit.sv
module radio_trac_unit
  import radio_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rstate_t           state,
  input  logic              ext_start,
  input  logic              done,
  input  logic [STAT_W-1:0] result,
  input  logic              slotted_en,
  input  logic              ack_trigger,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              ack_go
);
  logic              in_rx, in_tx;
  logic [STAT_W-1:0] kept;

  assign in_rx = (state == ST_RXAUTO);
  assign in_tx = (state == ST_TXRTRY);

  always_comb begin
    kept = TS_INVALID;
    if (in_rx) begin
      if (result == TS_OK) kept = TS_OK;
      else if (result == TS_WAITACK && slotted_en) kept = TS_WAITACK;
    end else if (in_tx) begin
      if (result == TS_OK || result == TS_PEND || result == TS_CAF ||
          result == TS_NOACK) kept = result;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= TS_OK;
      irq    <= 1'b0;
      ack_go <= 1'b0;
    end else begin
      irq    <= 1'b0;
      ack_go <= in_rx && (status == TS_WAITACK) && ack_trigger;
      if (ext_start) begin
        status <= TS_INVALID;
      end else if (done && (in_rx || in_tx)) begin
        status <= kept;
        irq    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/radio_state_ctrl.sv
module radio_state_ctrl
  import radio_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ext_mode_en,
  input  logic             slotted_en,
  input  logic             sym_tick,
  input  logic             sleep_req,
  input  logic             proc_done,
  input  logic [STAT_W-1:0] proc_result,
  input  logic             ack_trigger,
  output logic [3:0]       state_o,
  output logic             tx_go,
  output logic             trac_irq,
  output logic             ack_go
);
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] status;
  op_t               op;
  rstate_t           state;
  logic              ext_start;

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else if (reg_wr) cmd_q <= reg_wdata[CMD_W-1:0];
  end

  radio_cmd_decode u_dec (.code(reg_wdata[CMD_W-1:0]), .op(op));

  radio_state_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .op(op), .ext_en(ext_mode_en),
    .sym_tick(sym_tick), .done(proc_done), .sleep_req(sleep_req),
    .state(state), .tx_go(tx_go), .ext_start(ext_start)
  );

  radio_trac_unit u_trac (
    .clk(clk), .rst_n(rst_n), .state(state), .ext_start(ext_start),
    .done(proc_done), .result(proc_result), .slotted_en(slotted_en),
    .ack_trigger(ack_trigger), .status(status), .irq(trac_irq), .ack_go(ack_go)
  );

  assign reg_rdata = {status, cmd_q};
  assign state_o   = state;
endmodule

// File: rtl/radio_state_ctrl_chk.sv
module radio_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] state_o,
  input logic [7:0] reg_rdata,
  input logic       trac_irq,
  input logic       tx_go,
  input logic       ack_go,
  input logic       sym_tick,
  input logic       slotted_en
);
  logic [2:0] st;
  assign st = reg_rdata[7:5];

  // R9: entering an extended state shows INVALID status
  assert_ext_entry_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 4'd6 || state_o == 4'd7) && $past(state_o) != state_o) |-> st == 3'd7);

  // R10: completion pulse lasts one cycle
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trac_irq |=> !trac_irq);

  // R5: frame start follows a tick seen while waiting
  assert_txgo_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |-> ($past(state_o) == 4'd4 && $past(sym_tick) && state_o == 4'd5));

  // R6: never jump from power-on or sleep straight to PLL-ready
  assert_no_forced_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 4'd0 || $past(state_o) == 4'd8) |-> state_o != 4'd2);

  // R10: auto-ACK receive never shows a transmit-only status
  assert_rx_status_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd6) |-> (st == 3'd0 || st == 3'd2 || st == 3'd7));

  // R11: wait-for-ACK appears only with slotted operation
  assert_waitack_slotted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trac_irq && st == 3'd2) |-> $past(slotted_en));

  // R11: ACK release is a single-cycle pulse
  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_go |=> !ack_go);
endmodule

bind radio_state_ctrl radio_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .reg_rdata(reg_rdata),
  .trac_irq(trac_irq), .tx_go(tx_go), .ack_go(ack_go),
  .sym_tick(sym_tick), .slotted_en(slotted_en)
);

// File: tb/radio_state_ctrl_test.sv
module radio_state_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_mode_en = 1'b1, slotted_en = 1'b0, sym_tick = 1'b0;
  logic       sleep_req = 1'b0, proc_done = 1'b0, ack_trigger = 1'b0;
  logic [2:0] proc_result = '0;
  logic [3:0] state_o;
  logic       tx_go, trac_irq, ack_go;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  radio_state_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_mode_en(ext_mode_en), .slotted_en(slotted_en),
    .sym_tick(sym_tick), .sleep_req(sleep_req), .proc_done(proc_done),
    .proc_result(proc_result), .ack_trigger(ack_trigger), .state_o(state_o),
    .tx_go(tx_go), .trac_irq(trac_irq), .ack_go(ack_go)
  );

  // {wdata, expected state, expected readback}
  localparam logic [19:0] VEC [12] = '{
    {8'h09, 4'd0, 8'h09},  // R6 PLL_ON ignored in power-on
    {8'h04, 4'd0, 8'h04},  // R6 forced PLL ignored in power-on
    {8'h08, 4'd1, 8'h08},  // R3 off
    {8'h06, 4'd3, 8'h06},  // R3 receive
    {8'h1F, 4'd3, 8'h1F},  // R4 reserved, R2 readback
    {8'hE9, 4'd2, 8'h09},  // R2 status bits ignored, R3 PLL
    {8'h00, 4'd2, 8'h00},  // R4 NOP
    {8'h16, 4'd6, 8'hF6},  // R8 R9 auto-ACK receive, status 7
    {8'h03, 4'd1, 8'hE3},  // R3 forced off, R12 status held
    {8'h04, 4'd2, 8'hE4},  // R6 forced PLL from off
    {8'h19, 4'd7, 8'hF9},  // R8 R9 auto-retry transmit
    {8'h06, 4'd3, 8'hE6}   // R12 status held
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic done_with(input logic [2:0] r);
    @(negedge clk); proc_done = 1'b1; proc_result = r;
    @(negedge clk); proc_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", reg_rdata, 8'h00);
    check("R1 state", state_o, 0);
    check("R1 pulses", {tx_go, trac_irq, ack_go}, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][19:12]);
      check($sformatf("R3 vec%0d state", i), state_o, VEC[i][11:8]);
      check($sformatf("R2 vec%0d rdata", i), reg_rdata, VEC[i][7:0]);
    end

    // R8: extended command ignored without extended mode
    ext_mode_en = 1'b0;
    wr(8'h16);
    check("R8 ext disabled", state_o, 3);
    ext_mode_en = 1'b1;

    // R5: delayed transmit start
    wr(8'h09);
    wr(8'h02);
    check("R5 wait state", state_o, 4);
    check("R5 no early go", tx_go, 0);
    wr(8'h06);
    check("R5 command locked out", state_o, 4);
    @(negedge clk); sym_tick = 1'b1;
    @(negedge clk); sym_tick = 1'b0;
    check("R5 tx_go", tx_go, 1);
    check("R5 busy", state_o, 5);
    @(negedge clk);
    check("R5 tx_go single", tx_go, 0);
    done_with(3'd0);
    check("R5 back to PLL", state_o, 2);
    check("R12 status held after tx", reg_rdata[7:5], 7);

    // R7 + R6: sleep
    wr(8'h08);
    sleep_req = 1'b1;
    @(negedge clk);
    check("R7 sleep", state_o, 8);
    wr(8'h04);
    check("R6 forced PLL ignored in sleep", state_o, 8);
    wr(8'h06);
    check("R7 command ignored in sleep", state_o, 8);
    sleep_req = 1'b0;
    @(negedge clk);
    check("R7 wake", state_o, 1);

    // R10/R11: auto-ACK receive completions
    slotted_en = 1'b0;
    wr(8'h16);
    @(negedge clk); proc_done = 1'b1; proc_result = 3'd2;
    @(negedge clk); proc_done = 1'b0;
    check("R11 waitack w/o slotted", reg_rdata[7:5], 7);
    check("R10 irq", trac_irq, 1);
    @(negedge clk);
    check("R10 irq single", trac_irq, 0);
    slotted_en = 1'b1;
    done_with(3'd2);
    check("R11 waitack slotted", reg_rdata[7:5], 2);
    @(negedge clk); ack_trigger = 1'b1;
    @(negedge clk); ack_trigger = 1'b0;
    check("R11 ack_go", ack_go, 1);
    @(negedge clk);
    check("R11 ack_go single", ack_go, 0);
    done_with(3'd5);
    check("R10 rx rejects no-ack", reg_rdata[7:5], 7);

    // R10: auto-retry transmit completions
    wr(8'h19);
    check("R9 restart invalid", reg_rdata[7:5], 7);
    done_with(3'd1);
    check("R10 tx pending", reg_rdata[7:5], 1);
    done_with(3'd2);
    check("R10 tx rejects waitack", reg_rdata[7:5], 7);
    done_with(3'd5);
    check("R10 tx no-ack", reg_rdata[7:5], 5);
    wr(8'h09);
    check("R12 status held", reg_rdata[7:5], 5);
    check("R12 state PLL", state_o, 2);
    wr(8'h16);
    check("R9 start resets status", reg_rdata[7:5], 7);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule